// File: doc/BRIEF.md
# Local Exclusive Access Monitor

This block sits beside one core's memory pipeline and decides whether each store-exclusive of an atomic read-modify-write sequence may commit. It watches the local operations each cycle: load-exclusive, store-exclusive, plain store and none. It also takes a clear request, raised by the context-switch path, and a snoop port that reports writes made by other agents. Internally it holds a two-state machine, open or exclusive, and the address tag of the granule that the last load-exclusive touched.

For every store-exclusive the monitor returns, one cycle later, a status word with a valid strobe. It also returns a memory write enable that is high only when the store may commit. The monitor does not record which task armed it. Any later load-exclusive re-arms it, so a store-exclusive from a task that was preempted can still succeed unless a clear happened in between. Software is expected to clear the monitor on every context switch and to retry whenever the status reports a failure.

Top module: `excl_monitor`

## Requirements
- R1: After reset the monitor is open, the status strobe and the write enable are low, and the first store-exclusive fails.
- R2: A load-exclusive (op code 2'b01) arms the monitor and replaces any earlier tag. After a load-exclusive to granule A and a later one to granule B, a store-exclusive to A fails.
- R3: A store-exclusive (op code 2'b10) to the tagged granule while armed succeeds, and the monitor is open afterwards, so an immediate second store-exclusive fails.
- R4: A store-exclusive while the monitor is open fails, and the write enable stays low.
- R5: The status strobe is high exactly in the cycle after each store-exclusive and low otherwise. The status word is SW bits wide: 0 means success and 1 means failure. The write enable is high only together with a success status.
- R6: A clear request returns the monitor to open at the next edge. A clear in the same cycle as a store-exclusive makes that store fail.
- R7: A snoop write whose address falls in the tagged granule disarms the monitor, and a snoop write in the same cycle as a store-exclusive to that granule makes the store fail. A snoop write to another granule has no effect.
- R8: Addresses are compared at a granule of GRAN_BYTES bytes (default 8) by ignoring the low address bits. A store-exclusive to another granule fails and still leaves the monitor open.
- R9: A plain store (op code 2'b11) from the local core, even to the tagged granule, leaves the state and tag unchanged. Op code 2'b00 means no operation.
- R10: The monitor holds no task identity. If task A arms it, task B arms it and completes, and task C arms it again, a store-exclusive from A succeeds. A clear issued between these steps makes A's store fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Local operation code: 00 none, 01 load-exclusive, 10 store-exclusive, 11 plain store |
| addr_i | input | AW | Byte address of the local operation |
| clr_i | input | 1 | Clear request from the context-switch path |
| snp_wr_i | input | 1 | A write by another agent is reported this cycle |
| snp_addr_i | input | AW | Byte address of the snooped write |
| mem_we_o | output | 1 | Store-exclusive may commit (registered) |
| sts_valid_o | output | 1 | Status strobe, one cycle after a store-exclusive |
| sts_code_o | output | SW | Status word: 0 success, 1 failure |

## Verification
The bench aims at the cases where a monitor passes a store it should refuse. These are a store to a different granule but a nearby address, a clear or a snoop that lands in the same cycle as the store, and the three-task interleaving with and without a clear. A design that compared full addresses would fail a store to another byte of the tagged granule. A design that gave the store priority over a clear would let it commit. A design that failed to close after a store would let a second store succeed. A design in which plain local stores disarmed the monitor would fail stores that should succeed, and a status register off by one cycle would show up on every random check.

// File: rtl/excl_pkg.sv
package excl_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_LDX  = 2'b01,
    OP_STX  = 2'b10,
    OP_ST   = 2'b11
  } mon_op_e;

  typedef enum logic {
    MON_OPEN = 1'b0,
    MON_EXCL = 1'b1
  } mon_state_e;
endpackage

// File: rtl/excl_tag_match.sv
module excl_tag_match #(
  parameter int AW   = 32,
  parameter int GLSB = 3
) (
  input  logic [AW-1:0]      addr_i,
  input  logic [AW-GLSB-1:0] tag_i,
  output logic               hit_o
);
  localparam logic [AW-1:0] GMASK = ~((AW'(1) << GLSB) - AW'(1));

  logic [AW-1:0] tag_addr;

  assign tag_addr = {tag_i, {GLSB{1'b0}}};
  assign hit_o    = ((addr_i ^ tag_addr) & GMASK) == '0;
endmodule

// File: rtl/excl_state_fsm.sv
module excl_state_fsm
  import excl_pkg::*;
#(
  parameter int TW = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mon_op_e       op_i,
  input  logic [TW-1:0] gran_i,
  input  logic          clr_i,
  input  logic          snp_hit_i,
  output mon_state_e    state_o,
  output logic [TW-1:0] tag_o
);
  mon_state_e    state_q, state_d;
  logic [TW-1:0] tag_q;
  logic          tag_en;

  always_comb begin
    state_d = state_q;
    tag_en  = 1'b0;
    if (clr_i) begin
      state_d = MON_OPEN;
    end else if (op_i == OP_LDX) begin
      state_d = MON_EXCL;
      tag_en  = 1'b1;
    end else if (op_i == OP_STX) begin
      state_d = MON_OPEN;
    end else if (snp_hit_i) begin
      state_d = MON_OPEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MON_OPEN;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tag_q <= '0;
    else if (tag_en) tag_q <= gran_i;
  end

  assign state_o = state_q;
  assign tag_o   = tag_q;

  // R6
  clr_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> state_q == MON_OPEN);
  // R2
  ldx_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_LDX && !clr_i) |=> (state_q == MON_EXCL && tag_q == $past(gran_i)));
  // R3
  stx_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_STX) |=> state_q == MON_OPEN);
  // R9
  plain_st_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ST && !clr_i && !snp_hit_i) |=> ($stable(state_q) && $stable(tag_q)));
endmodule

// File: rtl/excl_status_reg.sv
module excl_status_reg #(
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stx_i,
  input  logic          pass_i,
  output logic          we_o,
  output logic          vld_o,
  output logic [SW-1:0] code_o
);
  logic          vld_d, we_d;
  logic [SW-1:0] code_d;

  always_comb begin
    vld_d  = stx_i;
    we_d   = stx_i & pass_i;
    code_d = '0;
    if (stx_i && !pass_i) code_d = SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      we_o   <= 1'b0;
      code_o <= '0;
    end else begin
      vld_o  <= vld_d;
      we_o   <= we_d;
      code_o <= code_d;
    end
  end

  // R5
  sts_only_after_stx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> $past(stx_i));
  // R5
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_o <= SW'(1));
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SW         = 32,
  parameter int GRAN_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic          clr_i,
  input  logic          snp_wr_i,
  input  logic [AW-1:0] snp_addr_i,
  output logic          mem_we_o,
  output logic          sts_valid_o,
  output logic [SW-1:0] sts_code_o
);
  localparam int GLSB = $clog2(GRAN_BYTES);
  localparam int TW   = AW - GLSB;

  mon_op_e       op;
  mon_state_e    state;
  logic [TW-1:0] tag;
  logic          req_hit, snp_match, snp_hit, stx, pass;

  assign op = mon_op_e'(op_i);

  excl_tag_match #(.AW(AW), .GLSB(GLSB)) u_req_match (
    .addr_i (addr_i),
    .tag_i  (tag),
    .hit_o  (req_hit)
  );

  excl_tag_match #(.AW(AW), .GLSB(GLSB)) u_snp_match (
    .addr_i (snp_addr_i),
    .tag_i  (tag),
    .hit_o  (snp_match)
  );

  assign snp_hit = snp_wr_i & snp_match;

  excl_state_fsm #(.TW(TW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op),
    .gran_i    (addr_i[AW-1:GLSB]),
    .clr_i     (clr_i),
    .snp_hit_i (snp_hit),
    .state_o   (state),
    .tag_o     (tag)
  );

  assign stx  = (op == OP_STX);
  assign pass = (state == MON_EXCL) & req_hit & ~clr_i & ~snp_hit;

  excl_status_reg #(.SW(SW)) u_sts (
    .clk    (clk),
    .rst_n  (rst_n),
    .stx_i  (stx),
    .pass_i (pass),
    .we_o   (mem_we_o),
    .vld_o  (sts_valid_o),
    .code_o (sts_code_o)
  );

  // R4
  we_needs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(state == MON_EXCL));
  // R5
  we_with_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (sts_valid_o && sts_code_o == '0));
  // R6
  clr_blocks_stx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && stx) |=> (sts_valid_o && !mem_we_o));
endmodule

// File: tb/excl_monitor_test.sv
module excl_monitor_test;
  localparam int AW = 32;
  localparam int SW = 32;
  localparam logic [1:0] NOP = 2'b00, LDX = 2'b01, STX = 2'b10, PST = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    op;
  logic [AW-1:0] addr, saddr;
  logic          clr, swr;
  logic          we, vld;
  logic [SW-1:0] code;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;
  bit  m_excl;
  logic [AW-4:0] m_tag;

  always #2 clk = ~clk;

  excl_monitor #(.AW(AW), .SW(SW), .GRAN_BYTES(8)) uut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .addr_i(addr), .clr_i(clr),
    .snp_wr_i(swr), .snp_addr_i(saddr), .mem_we_o(we), .sts_valid_o(vld),
    .sts_code_o(code)
  );

  function automatic bit ref_pass(logic [1:0] o, logic [AW-1:0] a, bit c,
                                  bit s, logic [AW-1:0] sa);
    bit shit = s && (sa[AW-1:3] == m_tag);
    return (o == STX) && m_excl && (a[AW-1:3] == m_tag) && !c && !shit;
  endfunction

  task automatic ref_update(logic [1:0] o, logic [AW-1:0] a, bit c, bit s,
                            logic [AW-1:0] sa);
    bit shit = s && (sa[AW-1:3] == m_tag);
    if (c) m_excl = 0;
    else if (o == LDX) begin m_excl = 1; m_tag = a[AW-1:3]; end
    else if (o == STX) m_excl = 0;
    else if (shit) m_excl = 0;
  endtask

  task automatic step(logic [1:0] o, logic [AW-1:0] a, bit c, bit s,
                      logic [AW-1:0] sa, string req);
    bit ev = (o == STX);
    bit ep = ref_pass(o, a, c, s, sa);
    logic [SW-1:0] ec = (ev && !ep) ? SW'(1) : SW'(0);
    ref_update(o, a, c, s, sa);
    op = o; addr = a; clr = c; swr = s; saddr = sa;
    @(negedge clk);
    n_chk++;
    if (vld !== ev || we !== ep || (ev && code !== ec)) begin
      n_fail++;
      $display("FAIL %s: vld=%0b we=%0b code=%0d expected vld=%0b we=%0b code=%0d",
               req, vld, we, code, ev, ep, ec);
    end
  endtask

  task automatic idle(string req);
    step(NOP, '0, 0, 0, '0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_excl = 0; m_tag = '0;
    op = NOP; addr = '0; clr = 0; swr = 0; saddr = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    n_chk++;
    if (vld !== 0 || we !== 0) begin
      n_fail++;
      $display("FAIL R1 reset: vld=%0b we=%0b expected 0 0", vld, we);
    end
    step(STX, 32'h100, 0, 0, '0, "R1 first stx fails");
    step(STX, 32'h100, 0, 0, '0, "R4 stx while open");
    // R3 and R8: same granule, different byte
    step(LDX, 32'h100, 0, 0, '0, "R2 arm");
    step(STX, 32'h104, 0, 0, '0, "R8 same granule passes / R3");
    step(STX, 32'h100, 0, 0, '0, "R3 second stx fails");
    // R8 other granule
    step(LDX, 32'h100, 0, 0, '0, "R2 arm");
    step(STX, 32'h108, 0, 0, '0, "R8 other granule fails");
    step(STX, 32'h100, 0, 0, '0, "R8 open after mismatch");
    // R2 retag
    step(LDX, 32'h100, 0, 0, '0, "R2 arm A");
    step(LDX, 32'h200, 0, 0, '0, "R2 arm B");
    step(STX, 32'h100, 0, 0, '0, "R2 old tag fails");
    // R6
    step(LDX, 32'h200, 0, 0, '0, "R6 arm");
    step(NOP, '0, 1, 0, '0, "R6 clear");
    step(STX, 32'h200, 0, 0, '0, "R6 stx after clear fails");
    step(LDX, 32'h300, 0, 0, '0, "R6 arm");
    step(STX, 32'h300, 1, 0, '0, "R6 clear with stx fails");
    // R9
    step(LDX, 32'h300, 0, 0, '0, "R9 arm");
    step(PST, 32'h300, 0, 0, '0, "R9 plain store");
    step(STX, 32'h300, 0, 0, '0, "R9 stx still passes");
    // R7
    step(LDX, 32'h300, 0, 0, '0, "R7 arm");
    step(NOP, '0, 0, 1, 32'h308, "R7 snoop other granule");
    step(STX, 32'h300, 0, 0, '0, "R7 stx passes after miss");
    step(LDX, 32'h300, 0, 0, '0, "R7 arm");
    step(NOP, '0, 0, 1, 32'h304, "R7 snoop hit");
    step(STX, 32'h300, 0, 0, '0, "R7 stx fails after hit");
    step(LDX, 32'h300, 0, 0, '0, "R7 arm");
    step(STX, 32'h300, 0, 1, 32'h300, "R7 snoop same cycle fails");
    // R10 three tasks, no clear
    step(LDX, 32'h400, 0, 0, '0, "R10 task A arms");
    step(LDX, 32'h400, 0, 0, '0, "R10 task B arms");
    step(STX, 32'h400, 0, 0, '0, "R10 task B commits");
    step(LDX, 32'h400, 0, 0, '0, "R10 task C arms");
    step(STX, 32'h400, 0, 0, '0, "R10 stale task A passes");
    // R10 with clears on each switch
    step(LDX, 32'h400, 0, 0, '0, "R10 task A arms");
    step(NOP, '0, 1, 0, '0, "R10 switch clear");
    step(LDX, 32'h400, 0, 0, '0, "R10 task B arms");
    step(STX, 32'h400, 0, 0, '0, "R10 task B commits");
    step(LDX, 32'h400, 0, 0, '0, "R10 task C arms");
    step(NOP, '0, 1, 0, '0, "R10 switch clear");
    step(STX, 32'h400, 0, 0, '0, "R10 task A fails");
    idle("R5 no strobe without stx");
    // R5 random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0]    ro = 2'($urandom_range(0, 3));
      logic [AW-1:0] ra = AW'($urandom_range(0, 31));
      logic [AW-1:0] rs = AW'($urandom_range(0, 31));
      bit rc = ($urandom_range(0, 15) == 0);
      bit rw = ($urandom_range(0, 5) == 0);
      step(ro, ra, rc, rw, rs, "R5 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule